// File: doc/BRIEF.md
# Cache-Side Coherence Agent for One Block

This block is the coherence engine that sits beside one cache line. It tracks the line through the four stable MESI states and five in-between states. Loads and stores from the local core come in on one port. Commands and data from the directory, and data from peer caches, come in on an inbound message port. When the line misses, or a shared line is written, the agent issues a read or write request. It answers invalidations, transfers and writebacks, and it acknowledges each completed fill on the proper virtual channel.

Tag and data for a fill may arrive in either order, so the wait state splits into three. Data from the directory and data from a peer lead to different acknowledgements, so the agent records which source delivered the data. Every outbound message passes through a one-entry output register with a valid/ready handshake. While that register is full and not being drained, neither input port is taken.

Top module: `coh_agent`

## Requirements
- R1: After synchronous reset, `line_state` reads 0 (invalid), `line_value` is 0, and `busy`, `out_valid` and `proto_err` are all 0.
- R2: In invalid and not busy, a local request is taken as follows: a load (op 0) emits a read request (type 0), and a store (op 1) emits a write request (type 1) with upgrade 0. Both go on channel 0. The line then enters wait-both (4) with `busy` set. Any local request taken while `busy` is set emits nothing and changes nothing. A store that misses does not write the value.
- R3: In wait-both, a tag command (type 0) with next state S (1), E (2) or M (3) moves the line to wait-data (5). When data then arrives, it is stored, the line takes the saved next state and `busy` clears. Data from the directory (type 5) is answered by a coherence ack (type 3). Data from a peer (type 6) is answered by a transfer ack (type 4). Both acks go on channel 3.
- R4: In wait-both, data from either source is stored and the line moves to wait-tag (6). The tag command that follows moves the line to the commanded state, clears `busy` and emits an ack on channel 3. That ack is a transfer ack if the data came from a peer, and a coherence ack otherwise.
- R5: An invalidate command (type 2) always emits an invalidate ack (type 2) on channel 3. The line moves from S (1) or E (2) to invalid, from M (3) to invalid-dirty (7), and from shared-upgrading (8) to wait-both.
- R6: A local store in S (1) emits a write request (type 1) with upgrade 1 and enters shared-upgrading (8) with `busy` set. A wakeup command (type 1) in that state moves the line to M, clears `busy` and emits a coherence ack.
- R7: A transfer command (type 3) in invalid, invalid-dirty or wait-both emits peer data (type 5) on channel 2. The message carries the held value and the command's target, and the state does not change.
- R8: A writeback command (type 4) in invalid or wait-both emits a null response (type 6). In invalid-dirty it emits a data response (type 7) and the line moves to invalid. Both responses go on channel 4 and carry the held value.
- R9: A store in E writes the value and moves the line to M without a message. A store in M only writes the value. A load in S, E or M emits nothing.
- R10: While `out_valid` is 1 and `out_ready` is 0, the outbound fields hold steady, `in_ready` and `req_ready` are 0, and the state does not move. An inbound message takes priority over a local request offered in the same cycle.
- R11: A message that is illegal in the current state sets `proto_err`, which stays set until reset. The message emits nothing and changes neither the state nor the value. A tag command whose next state is not S, E or M counts as illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 1 | 0 load, 1 store |
| req_data | input | VAL_W | Store data |
| req_ready | output | 1 | Local request taken this cycle |
| in_valid | input | 1 | Inbound message present |
| in_type | input | 3 | Inbound message type |
| in_value | input | VAL_W | Data carried by a data message |
| in_target | input | ID_W | Destination agent for a transfer command |
| in_next | input | 4 | Next state carried by a tag command |
| in_ready | output | 1 | Inbound message taken this cycle |
| out_valid | output | 1 | Outbound message present |
| out_ready | input | 1 | Outbound message accepted by the network |
| out_type | output | 3 | Outbound message type |
| out_vc | output | 3 | Virtual channel of the outbound message |
| out_value | output | VAL_W | Value carried by data and writeback messages |
| out_target | output | ID_W | Destination of peer data |
| out_upgrade | output | 1 | Write request is an upgrade |
| line_state | output | 4 | Current line state code |
| line_value | output | VAL_W | Value held for the line |
| busy | output | 1 | A request is outstanding |
| proto_err | output | 1 | Sticky illegal-message flag |

## Verification
A wrong internal state shows on `line_state` at the first clock edge after the message that caused it. It also shows in the type or channel of the next message the agent emits. A wrong source record for fill data does not appear until the completing half arrives: the ack type is wrong at that edge. A lost held value shows up only at a later transfer or writeback, when `out_value` is compared with the last value stored. The bench therefore runs long random sequences that use only legal messages and mirrors each one in a reference model. After every transaction it compares the message, the state, the value and the busy flag.

// File: rtl/coh_agent_pkg.sv
package coh_agent_pkg;

    typedef enum logic [3:0] {
        LS_I       = 4'd0,
        LS_S       = 4'd1,
        LS_E       = 4'd2,
        LS_M       = 4'd3,
        LS_WAIT_TD = 4'd4,
        LS_WAIT_D  = 4'd5,
        LS_WAIT_T  = 4'd6,
        LS_IDIRTY  = 4'd7,
        LS_S_UPG   = 4'd8
    } line_state_e;

    typedef enum logic [2:0] {
        IN_TAG       = 3'd0,
        IN_WAKE      = 3'd1,
        IN_INV       = 3'd2,
        IN_XFER      = 3'd3,
        IN_WB        = 3'd4,
        IN_DATA_HOME = 3'd5,
        IN_DATA_PEER = 3'd6
    } in_kind_e;

    typedef enum logic [2:0] {
        OUT_RD_REQ    = 3'd0,
        OUT_WR_REQ    = 3'd1,
        OUT_INV_ACK   = 3'd2,
        OUT_COH_ACK   = 3'd3,
        OUT_XFER_ACK  = 3'd4,
        OUT_PEER_DATA = 3'd5,
        OUT_WB_NULL   = 3'd6,
        OUT_WB_DATA   = 3'd7
    } out_kind_e;

    localparam int VC_W = 3;
    localparam logic [VC_W-1:0] VC_REQ    = 3'd0;
    localparam logic [VC_W-1:0] VC_PEER   = 3'd2;
    localparam logic [VC_W-1:0] VC_ACK    = 3'd3;
    localparam logic [VC_W-1:0] VC_WBRESP = 3'd4;

    function automatic logic [VC_W-1:0] chan_for(input out_kind_e k);
        case (k)
            OUT_RD_REQ, OUT_WR_REQ:                return VC_REQ;
            OUT_PEER_DATA:                         return VC_PEER;
            OUT_WB_NULL, OUT_WB_DATA:              return VC_WBRESP;
            default:                               return VC_ACK;
        endcase
    endfunction

    function automatic logic is_fill_state(input line_state_e s);
        return (s == LS_S) || (s == LS_E) || (s == LS_M);
    endfunction

endpackage

// File: rtl/coh_agent_txbuf.sv
module coh_agent_txbuf
    import coh_agent_pkg::*;
#(
    parameter int VAL_W = 8,
    parameter int ID_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  out_kind_e        kind,
    input  logic [VAL_W-1:0] value,
    input  logic [ID_W-1:0]  target,
    input  logic             upgrade,
    input  logic             out_ready,
    output logic             can_emit,
    output logic             out_valid,
    output out_kind_e        out_kind,
    output logic [VC_W-1:0]  out_vc,
    output logic [VAL_W-1:0] out_value,
    output logic [ID_W-1:0]  out_target,
    output logic             out_upgrade
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_kind    <= OUT_RD_REQ;
            out_value   <= '0;
            out_target  <= '0;
            out_upgrade <= 1'b0;
        end else if (load) begin
            out_valid   <= 1'b1;
            out_kind    <= kind;
            out_value   <= value;
            out_target  <= target;
            out_upgrade <= upgrade;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

    assign can_emit = !out_valid || out_ready;
    assign out_vc   = chan_for(out_kind);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_value)
                                    && $stable(out_target)); // R10

    AST_ACK_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_kind inside {OUT_INV_ACK, OUT_COH_ACK, OUT_XFER_ACK})
        |-> out_vc == 3'd3); // R3

    AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !load); // R10

endmodule

// File: rtl/coh_agent_ctrl.sv
module coh_agent_ctrl
    import coh_agent_pkg::*;
#(
    parameter int VAL_W = 8,
    parameter int ID_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  in_kind_e         in_kind,
    input  logic [VAL_W-1:0] in_value,
    input  logic [ID_W-1:0]  in_target,
    input  line_state_e      in_next,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic [VAL_W-1:0] req_data,
    input  logic             can_emit,
    output logic             in_take,
    output logic             req_take,
    output logic             emit,
    output out_kind_e        emit_kind,
    output logic [VAL_W-1:0] emit_value,
    output logic [ID_W-1:0]  emit_target,
    output logic             emit_upgrade,
    output line_state_e      state_q,
    output logic [VAL_W-1:0] value_q,
    output logic             blocked_q,
    output logic             err_q
);

    line_state_e      state_d, saved_q, saved_d;
    logic [VAL_W-1:0] value_d;
    logic             blocked_d, xfer_q, xfer_d, err_d, bad;

    assign in_take  = in_valid && can_emit;
    assign req_take = req_valid && !in_valid && can_emit;

    always_comb begin
        state_d      = state_q;
        saved_d      = saved_q;
        value_d      = value_q;
        blocked_d    = blocked_q;
        xfer_d       = xfer_q;
        err_d        = err_q;
        bad          = 1'b0;
        emit         = 1'b0;
        emit_kind    = OUT_RD_REQ;
        emit_value   = '0;
        emit_target  = '0;
        emit_upgrade = 1'b0;
        if (in_take) begin
            bad = 1'b1;
            case (state_q)
                LS_I, LS_IDIRTY, LS_WAIT_TD: begin
                    if (in_kind == IN_XFER) begin
                        bad         = 1'b0;
                        emit        = 1'b1;
                        emit_kind   = OUT_PEER_DATA;
                        emit_value  = value_q;
                        emit_target = in_target;
                    end else if (in_kind == IN_WB) begin
                        bad        = 1'b0;
                        emit       = 1'b1;
                        emit_value = value_q;
                        if (state_q == LS_IDIRTY) begin
                            emit_kind = OUT_WB_DATA;
                            state_d   = LS_I;
                        end else begin
                            emit_kind = OUT_WB_NULL;
                        end
                    end else if (state_q == LS_WAIT_TD) begin
                        if (in_kind == IN_TAG && is_fill_state(in_next)) begin
                            bad     = 1'b0;
                            saved_d = in_next;
                            state_d = LS_WAIT_D;
                        end else if (in_kind == IN_DATA_HOME || in_kind == IN_DATA_PEER) begin
                            bad     = 1'b0;
                            value_d = in_value;
                            xfer_d  = (in_kind == IN_DATA_PEER);
                            state_d = LS_WAIT_T;
                        end
                    end
                end
                LS_WAIT_D: begin
                    if (in_kind == IN_DATA_HOME || in_kind == IN_DATA_PEER) begin
                        bad       = 1'b0;
                        emit      = 1'b1;
                        emit_kind = (in_kind == IN_DATA_PEER) ? OUT_XFER_ACK : OUT_COH_ACK;
                        value_d   = in_value;
                        state_d   = saved_q;
                        blocked_d = 1'b0;
                    end
                end
                LS_WAIT_T: begin
                    if (in_kind == IN_TAG && is_fill_state(in_next)) begin
                        bad       = 1'b0;
                        emit      = 1'b1;
                        emit_kind = xfer_q ? OUT_XFER_ACK : OUT_COH_ACK;
                        state_d   = in_next;
                        blocked_d = 1'b0;
                        xfer_d    = 1'b0;
                    end
                end
                LS_S, LS_E, LS_M: begin
                    if (in_kind == IN_INV) begin
                        bad       = 1'b0;
                        emit      = 1'b1;
                        emit_kind = OUT_INV_ACK;
                        state_d   = (state_q == LS_M) ? LS_IDIRTY : LS_I;
                    end
                end
                LS_S_UPG: begin
                    if (in_kind == IN_INV) begin
                        bad       = 1'b0;
                        emit      = 1'b1;
                        emit_kind = OUT_INV_ACK;
                        state_d   = LS_WAIT_TD;
                    end else if (in_kind == IN_WAKE) begin
                        bad       = 1'b0;
                        emit      = 1'b1;
                        emit_kind = OUT_COH_ACK;
                        state_d   = LS_M;
                        blocked_d = 1'b0;
                    end
                end
                default: ;
            endcase
            if (bad) err_d = 1'b1;
        end else if (req_take) begin
            case (state_q)
                LS_I: begin
                    if (!blocked_q) begin
                        emit      = 1'b1;
                        emit_kind = req_store ? OUT_WR_REQ : OUT_RD_REQ;
                        state_d   = LS_WAIT_TD;
                        blocked_d = 1'b1;
                    end
                end
                LS_S: begin
                    if (req_store && !blocked_q) begin
                        emit         = 1'b1;
                        emit_kind    = OUT_WR_REQ;
                        emit_upgrade = 1'b1;
                        state_d      = LS_S_UPG;
                        blocked_d    = 1'b1;
                    end
                end
                LS_E: begin
                    if (req_store) begin
                        value_d = req_data;
                        state_d = LS_M;
                    end
                end
                LS_M: begin
                    if (req_store) value_d = req_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LS_I;
            saved_q   <= LS_I;
            value_q   <= '0;
            blocked_q <= 1'b0;
            xfer_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            saved_q   <= saved_d;
            value_q   <= value_d;
            blocked_q <= blocked_d;
            xfer_q    <= xfer_d;
            err_q     <= err_d;
        end
    end

    AST_BUSY_ONLY_TRANSIENT: assert property (@(posedge clk) disable iff (rst)
        blocked_q |-> (state_q inside {LS_WAIT_TD, LS_WAIT_D, LS_WAIT_T, LS_S_UPG})); // R2

    AST_REQ_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        emit && (emit_kind inside {OUT_RD_REQ, OUT_WR_REQ}) |-> !blocked_q); // R2

    AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        emit && (emit_kind inside {OUT_RD_REQ, OUT_WR_REQ}) |=> blocked_q); // R2

    AST_ACK_FREES: assert property (@(posedge clk) disable iff (rst)
        emit && (emit_kind inside {OUT_COH_ACK, OUT_XFER_ACK}) |=> !blocked_q
                                                                  && is_fill_state(state_q)); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R11

    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $stable(state_q) && $stable(value_q)); // R11

endmodule

// File: rtl/coh_agent.sv
module coh_agent
    import coh_agent_pkg::*;
#(
    parameter int VAL_W = 8,
    parameter int ID_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic [VAL_W-1:0] req_data,
    output logic             req_ready,
    input  logic             in_valid,
    input  logic [2:0]       in_type,
    input  logic [VAL_W-1:0] in_value,
    input  logic [ID_W-1:0]  in_target,
    input  logic [3:0]       in_next,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_type,
    output logic [2:0]       out_vc,
    output logic [VAL_W-1:0] out_value,
    output logic [ID_W-1:0]  out_target,
    output logic             out_upgrade,
    output logic [3:0]       line_state,
    output logic [VAL_W-1:0] line_value,
    output logic             busy,
    output logic             proto_err
);

    logic             can_emit, emit, emit_upgrade;
    out_kind_e        emit_kind, held_kind;
    logic [VAL_W-1:0] emit_value;
    logic [ID_W-1:0]  emit_target;
    line_state_e      cur_state;

    coh_agent_ctrl #(.VAL_W(VAL_W), .ID_W(ID_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_kind      (in_kind_e'(in_type)),
        .in_value     (in_value),
        .in_target    (in_target),
        .in_next      (line_state_e'(in_next)),
        .req_valid    (req_valid),
        .req_store    (req_op),
        .req_data     (req_data),
        .can_emit     (can_emit),
        .in_take      (in_ready),
        .req_take     (req_ready),
        .emit         (emit),
        .emit_kind    (emit_kind),
        .emit_value   (emit_value),
        .emit_target  (emit_target),
        .emit_upgrade (emit_upgrade),
        .state_q      (cur_state),
        .value_q      (line_value),
        .blocked_q    (busy),
        .err_q        (proto_err)
    );

    coh_agent_txbuf #(.VAL_W(VAL_W), .ID_W(ID_W)) u_txbuf (
        .clk         (clk),
        .rst         (rst),
        .load        (emit),
        .kind        (emit_kind),
        .value       (emit_value),
        .target      (emit_target),
        .upgrade     (emit_upgrade),
        .out_ready   (out_ready),
        .can_emit    (can_emit),
        .out_valid   (out_valid),
        .out_kind    (held_kind),
        .out_vc      (out_vc),
        .out_value   (out_value),
        .out_target  (out_target),
        .out_upgrade (out_upgrade)
    );

    assign out_type   = held_kind;
    assign line_state = cur_state;

    AST_STALL_FREEZES_STATE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(line_state)); // R10

endmodule

// File: tb/coh_agent_tb.sv
`timescale 1ns/1ps
module coh_agent_tb;
    localparam int VAL_W = 8;
    localparam int ID_W  = 2;

    localparam int S_I = 0, S_S = 1, S_E = 2, S_M = 3, S_WTD = 4, S_WD = 5, S_WT = 6,
                   S_IDIRTY = 7, S_SUPG = 8;
    localparam int K_TAG = 0, K_WAKE = 1, K_INV = 2, K_XFER = 3, K_WB = 4,
                   K_HOME = 5, K_PEER = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_op = 1'b0, req_ready;
    logic [VAL_W-1:0] req_data = '0;
    logic in_valid = 1'b0, in_ready;
    logic [2:0] in_type = '0;
    logic [VAL_W-1:0] in_value = '0;
    logic [ID_W-1:0] in_target = '0;
    logic [3:0] in_next = '0;
    logic out_valid, out_ready = 1'b1, out_upgrade, busy, proto_err;
    logic [2:0] out_type, out_vc;
    logic [VAL_W-1:0] out_value, line_value;
    logic [ID_W-1:0] out_target;
    logic [3:0] line_state;

    coh_agent #(.VAL_W(VAL_W), .ID_W(ID_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_data(req_data),
        .req_ready(req_ready), .in_valid(in_valid), .in_type(in_type), .in_value(in_value),
        .in_target(in_target), .in_next(in_next), .in_ready(in_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_type(out_type), .out_vc(out_vc), .out_value(out_value),
        .out_target(out_target), .out_upgrade(out_upgrade), .line_state(line_state),
        .line_value(line_value), .busy(busy), .proto_err(proto_err)
    );

    always #10 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    int m_state, m_val, m_saved, m_busy, m_xfer, m_err;
    int e_emit, e_type, e_val, e_tgt, e_upg;
    string e_tag;

    task automatic cmp(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_vc(int t);
        if (t <= 1) return 0;
        if (t == 5) return 2;
        if (t >= 6) return 4;
        return 3;
    endfunction

    function automatic bit good_next(int ns);
        return ns >= S_S && ns <= S_M;
    endfunction

    task automatic model_reset();
        m_state = S_I; m_val = 0; m_saved = 0; m_busy = 0; m_xfer = 0; m_err = 0;
    endtask

    task automatic clear_exp();
        e_emit = 0; e_type = 0; e_val = 0; e_tgt = 0; e_upg = 0; e_tag = "R11";
    endtask

    task automatic model_in(int k, int v, int t, int ns);
        clear_exp();
        case (k)
            K_XFER: if (m_state == S_I || m_state == S_IDIRTY || m_state == S_WTD) begin
                e_emit = 1; e_type = 5; e_val = m_val; e_tgt = t; e_tag = "R7";
            end else m_err = 1;
            K_WB: if (m_state == S_I || m_state == S_WTD) begin
                e_emit = 1; e_type = 6; e_val = m_val; e_tag = "R8";
            end else if (m_state == S_IDIRTY) begin
                e_emit = 1; e_type = 7; e_val = m_val; m_state = S_I; e_tag = "R8";
            end else m_err = 1;
            K_TAG: if (m_state == S_WTD && good_next(ns)) begin
                m_saved = ns; m_state = S_WD; e_tag = "R3";
            end else if (m_state == S_WT && good_next(ns)) begin
                e_emit = 1; e_type = m_xfer ? 4 : 3; m_state = ns; m_busy = 0; m_xfer = 0;
                e_tag = "R4";
            end else m_err = 1;
            K_HOME, K_PEER: if (m_state == S_WTD) begin
                m_val = v; m_xfer = (k == K_PEER); m_state = S_WT; e_tag = "R4";
            end else if (m_state == S_WD) begin
                e_emit = 1; e_type = (k == K_PEER) ? 4 : 3; m_val = v; m_state = m_saved;
                m_busy = 0; e_tag = "R3";
            end else m_err = 1;
            K_INV: begin
                if (m_state == S_S || m_state == S_E) m_state = S_I;
                else if (m_state == S_M) m_state = S_IDIRTY;
                else if (m_state == S_SUPG) m_state = S_WTD;
                else begin m_err = 1; return; end
                e_emit = 1; e_type = 2; e_tag = "R5";
            end
            K_WAKE: if (m_state == S_SUPG) begin
                e_emit = 1; e_type = 3; m_state = S_M; m_busy = 0; e_tag = "R6";
            end else m_err = 1;
            default: m_err = 1;
        endcase
    endtask

    task automatic model_req(int op, int d);
        clear_exp();
        e_tag = m_busy ? "R2" : "R9";
        if (m_state == S_I && !m_busy) begin
            e_emit = 1; e_type = op; m_state = S_WTD; m_busy = 1; e_tag = "R2";
        end else if (m_state == S_S && op == 1 && !m_busy) begin
            e_emit = 1; e_type = 1; e_upg = 1; m_state = S_SUPG; m_busy = 1; e_tag = "R6";
        end else if (m_state == S_E && op == 1) begin
            m_val = d; m_state = S_M;
        end else if (m_state == S_M && op == 1) begin
            m_val = d;
        end
    endtask

    task automatic check_all();
        cmp(e_tag, "out_valid", int'(out_valid), e_emit);
        if (e_emit != 0 && out_valid) begin
            cmp(e_tag, "out_type", int'(out_type), e_type);
            cmp(e_tag, "out_vc", int'(out_vc), exp_vc(e_type));
            cmp(e_tag, "out_value", int'(out_value), e_val);
            cmp(e_tag, "out_target", int'(out_target), e_tgt);
            cmp(e_tag, "out_upgrade", int'(out_upgrade), e_upg);
        end
        cmp(e_tag, "line_state", int'(line_state), m_state);
        cmp(e_tag, "line_value", int'(line_value), m_val);
        cmp(e_tag, "busy", int'(busy), m_busy);
        cmp(e_tag, "proto_err", int'(proto_err), m_err);
    endtask

    task automatic send_in(int k, int v, int t, int ns);
        @(negedge clk);
        in_valid = 1'b1; in_type = 3'(k); in_value = VAL_W'(v);
        in_target = ID_W'(t); in_next = 4'(ns);
        model_in(k, v, t, ns);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check_all();
    endtask

    task automatic send_req(int op, int d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op[0]; req_data = VAL_W'(d);
        model_req(op, d);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; req_valid = 1'b0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        clear_exp();
        e_tag = "R1";
        check_all();
    endtask

    function automatic int pick_legal(int st, int r);
        case (st)
            S_I, S_IDIRTY: return (r % 2 == 0) ? K_XFER : K_WB;
            S_WTD: case (r % 5)
                0: return K_XFER; 1: return K_WB; 2: return K_TAG;
                3: return K_HOME; default: return K_PEER;
            endcase
            S_WD: return (r % 2 == 0) ? K_HOME : K_PEER;
            S_WT: return K_TAG;
            S_SUPG: return (r % 2 == 0) ? K_INV : K_WAKE;
            default: return K_INV;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        do_reset();

        // R3: tag first, data from directory; then R9 store in E
        send_req(0, 0);
        send_in(K_TAG, 0, 0, S_E);
        send_in(K_HOME, 8'h5a, 0, 0);
        send_req(0, 0);
        send_req(1, 8'h77);
        send_req(1, 8'h78);
        // R5 invalidate from M, then R7 transfer and R8 writeback in invalid-dirty
        send_in(K_INV, 0, 0, 0);
        send_in(K_XFER, 0, 2, 0);
        send_in(K_WB, 0, 0, 0);
        // R4 data from peer first, then tag into S; R6 upgrade then invalidate
        send_req(1, 8'h11);
        send_in(K_PEER, 8'h33, 0, 0);
        send_in(K_TAG, 0, 0, S_S);
        send_req(1, 8'h44);
        send_req(0, 0);
        send_in(K_INV, 0, 0, 0);
        send_in(K_HOME, 8'h9c, 0, 0);
        send_in(K_TAG, 0, 0, S_M);

        // R10: stall holds the message and blocks the inbound port
        do_reset();
        @(negedge clk);
        out_ready = 1'b0; req_valid = 1'b1; req_op = 1'b0;
        model_req(0, 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_all();
        in_valid = 1'b1; in_type = 3'(K_WB); in_value = '0; in_target = '0; in_next = '0;
        #1;
        cmp("R10", "in_ready during stall", int'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        cmp("R10", "held type", int'(out_type), 0);
        cmp("R10", "held valid", int'(out_valid), 1);
        cmp("R10", "state frozen", int'(line_state), S_WTD);
        out_ready = 1'b1;
        req_valid = 1'b1; req_op = 1'b1;
        #1;
        cmp("R10", "req_ready while inbound offered", int'(req_ready), 0);
        model_in(K_WB, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; req_valid = 1'b0;
        check_all();

        // R11: illegal data in invalid, bad tag next state, stickiness
        do_reset();
        send_in(K_HOME, 8'h21, 0, 0);
        send_in(K_WB, 0, 0, 0);
        do_reset();
        send_req(0, 0);
        send_in(K_TAG, 0, 0, S_I);
        send_in(K_INV, 0, 0, 0);

        // random legal traffic against the reference model
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom);
            if (r % 2 == 0) begin
                send_req((r >> 3) % 2, (r >> 8) & 8'hff);
            end else begin
                int k;
                k = pick_legal(m_state, (r >> 4) % 97);
                send_in(k, (r >> 12) & 8'hff, (r >> 20) % 4, 1 + ((r >> 24) % 3));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule